// File: doc/BRIEF.md
# Decoded Micro-op Cache Line Packer

This block sits behind an instruction decoder. It takes decoded instructions one at a time, in program order, and decides how their micro-ops are grouped into the ways of a decoded micro-op cache. Every instruction comes with its start address, its byte length, its micro-op count and four flags. The flags mark a conditional or other branch, an unconditional jump or call, an instruction sequenced from the microcode ROM, and a fused compare-and-branch pair. A way never mixes micro-ops from two aligned 32-byte code regions. A way also closes early when the slot budget, the branch budget, a microcode instruction, an unconditional transfer or a break in code contiguity requires it.

The ways of a region are held inside the block until the stream moves on to another region. They then leave as records in program order. Each record carries the region tag, the address of the way's first instruction, the slots used and the branches held. If a region needs more ways than it is allowed, a single record marks that region as uncacheable and none of its ways is sent. Valid/ready handshakes sit on the instruction side and on the record side. The instruction side is held off while records are being sent.

Top module: `uop_line_packer`

## Requirements
- R1: A region is the aligned 32-byte block given by in_addr[15:5], and out_tag is that value. An instruction is placed by the region of its start address, even when its bytes run past the region's end. Each way holds instructions of one region only, and a new region always begins a new way.
- R2: A way uses at most 6 slots. An instruction costs in_uops slots, or 1 slot when in_fused is set. An instruction that does not fit in the slots left begins a new way, so its micro-ops are never split.
- R3: A way holds at most 2 instructions with in_branch set. A third branch begins a new way.
- R4: An instruction with in_rom set occupies a way of its own, with its in_uops as the slot count. The way is closed before it and after it.
- R5: An instruction with in_uncond set is the last instruction of its way, even if slots remain.
- R6: An instruction whose address differs from the previous instruction's address plus length begins a new way starting at its own address, also inside the same region.
- R7: A region may use up to 3 ways. A region that needs a 4th way produces exactly one record with out_uncache=1, out_uops=0 and out_branches=0, and out_start={tag,5'b0}. None of its ways is sent.
- R8: The records of a region are sent in program order once an instruction of another region is presented. in_ready stays low from then until the last record is accepted. A record is held stable while out_valid is high and out_ready is low.
- R9: After reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Instruction accepted at the clock edge when high with in_valid |
| in_addr | input | 16 | Instruction start address |
| in_len | input | 4 | Instruction length in bytes |
| in_uops | input | 3 | Micro-op count |
| in_branch | input | 1 | Instruction is a branch |
| in_uncond | input | 1 | Instruction is an unconditional jump or call |
| in_rom | input | 1 | Instruction is sequenced from the microcode ROM |
| in_fused | input | 1 | Instruction is a fused compare-and-branch pair |
| out_valid | output | 1 | Record present |
| out_ready | input | 1 | Record consumed at the clock edge when high with out_valid |
| out_tag | output | 11 | Region tag |
| out_start | output | 16 | Address of the way's first instruction |
| out_uops | output | 3 | Slots used in the way |
| out_branches | output | 2 | Branches held in the way |
| out_uncache | output | 1 | Region marked uncacheable |

## Verification
An instruction is taken at the edge where in_ready and in_valid are both high. When an instruction of a new region is presented, in_ready falls combinationally in the same cycle. The first record of the previous region then shows on out_valid one edge later, and each further record one edge after the previous one is accepted. The bench drives and samples just after the falling edge, so it reads in_ready and the current record before the rising edge that acts on them. A reference model in the bench pushes the expected records of a region into a queue as soon as that region is left. Each record shown with out_ready high is compared to the head of that queue, so the comparison never depends on latency counts. The stall rule and the hold rule are checked at every handshake cycle.

// File: rtl/uop_line_pkg.sv
package uop_line_pkg;
    parameter int ADDR_W    = 16;
    parameter int LEN_W     = 4;
    parameter int UOP_W     = 3;
    parameter int BR_W      = 2;
    parameter int REGION_LG = 5;
    localparam int TAG_W    = ADDR_W - REGION_LG;

    typedef struct packed {
        logic [ADDR_W-1:0] start;
        logic [UOP_W-1:0]  uops;
        logic [BR_W-1:0]   br;
    } way_t;
endpackage

// File: rtl/upc_break_rule.sv
module upc_break_rule
    import uop_line_pkg::*;
#(
    parameter int SLOTS  = 6,
    parameter int MAX_BR = 2
) (
    input  way_t             open_way,
    input  logic [UOP_W-1:0] uops,
    input  logic             fused,
    input  logic             branch,
    input  logic             rom,
    input  logic             uncond,
    input  logic             disc,
    output logic [UOP_W-1:0] cost,
    output logic             brk_before,
    output logic             brk_after
);
    logic [UOP_W:0] fill_sum;
    logic           no_room;
    logic           br_full;

    always_comb begin
        cost       = fused ? UOP_W'(1) : uops;
        fill_sum   = {1'b0, open_way.uops} + {1'b0, cost};
        no_room    = fill_sum > (UOP_W+1)'(SLOTS);
        br_full    = branch && (open_way.br >= BR_W'(MAX_BR));
        brk_before = rom || disc || no_room || br_full;
        brk_after  = rom || uncond;
    end
endmodule

// File: rtl/upc_out_sel.sv
module upc_out_sel
    import uop_line_pkg::*;
#(
    parameter int MAX_WAYS = 3,
    parameter int WC_W     = 2
) (
    input  way_t [MAX_WAYS-1:0] ways,
    input  logic [WC_W-1:0]     idx,
    input  logic                ovf,
    input  logic [TAG_W-1:0]    tag,
    output logic [ADDR_W-1:0]   start,
    output logic [UOP_W-1:0]    uops,
    output logic [BR_W-1:0]     br
);
    always_comb begin
        if (ovf) begin
            start = {tag, {REGION_LG{1'b0}}};
            uops  = '0;
            br    = '0;
        end else begin
            start = ways[idx].start;
            uops  = ways[idx].uops;
            br    = ways[idx].br;
        end
    end
endmodule

// File: rtl/uop_line_packer.sv
module uop_line_packer
    import uop_line_pkg::*;
#(
    parameter int SLOTS    = 6,
    parameter int MAX_BR   = 2,
    parameter int MAX_WAYS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [LEN_W-1:0]  in_len,
    input  logic [UOP_W-1:0]  in_uops,
    input  logic              in_branch,
    input  logic              in_uncond,
    input  logic              in_rom,
    input  logic              in_fused,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [TAG_W-1:0]  out_tag,
    output logic [ADDR_W-1:0] out_start,
    output logic [UOP_W-1:0]  out_uops,
    output logic [BR_W-1:0]   out_branches,
    output logic              out_uncache
);
    localparam int WC_W = $clog2(MAX_WAYS + 1);

    typedef struct packed {
        logic                emit;
        logic                grp;
        logic [TAG_W-1:0]    tag;
        logic [ADDR_W-1:0]   nxt;
        logic                open_act;
        way_t                open;
        way_t [MAX_WAYS-1:0] ways;
        logic [WC_W-1:0]     n;
        logic                ovf;
        logic [WC_W-1:0]     idx;
    } st_t;

    st_t s_d, s_q;

    // Move the open way into the region buffer; a full buffer marks overflow.
    function automatic st_t close_way(st_t s);
        st_t r;
        r = s;
        if (r.open_act) begin
            if (r.n < WC_W'(MAX_WAYS)) begin
                r.ways[r.n] = r.open;
                r.n         = r.n + WC_W'(1);
            end else begin
                r.ovf = 1'b1;
            end
            r.open_act = 1'b0;
        end
        return r;
    endfunction

    logic [TAG_W-1:0] tag_in;
    logic             bnd;
    logic             disc;
    logic [UOP_W-1:0] cost;
    logic             brk_before;
    logic             brk_after;

    assign tag_in = in_addr[ADDR_W-1:REGION_LG];
    assign bnd    = in_valid && s_q.grp && (tag_in != s_q.tag);
    assign disc   = !s_q.grp || (in_addr != s_q.nxt);

    upc_break_rule #(.SLOTS(SLOTS), .MAX_BR(MAX_BR)) rule_i (
        .open_way   (s_q.open),
        .uops       (in_uops),
        .fused      (in_fused),
        .branch     (in_branch),
        .rom        (in_rom),
        .uncond     (in_uncond),
        .disc       (disc),
        .cost       (cost),
        .brk_before (brk_before),
        .brk_after  (brk_after)
    );

    always_comb begin
        s_d = s_q;
        if (!s_q.emit) begin
            if (bnd) begin
                s_d      = close_way(s_d);
                s_d.emit = 1'b1;
                s_d.idx  = '0;
            end else if (in_valid) begin
                if (!s_q.grp) begin
                    s_d.grp = 1'b1;
                    s_d.tag = tag_in;
                end
                s_d.nxt = in_addr + ADDR_W'(in_len);
                if (brk_before) begin
                    s_d = close_way(s_d);
                end
                if (!s_d.open_act) begin
                    s_d.open.start = in_addr;
                    s_d.open.uops  = cost;
                    s_d.open.br    = BR_W'(in_branch);
                    s_d.open_act   = 1'b1;
                end else begin
                    s_d.open.uops = s_d.open.uops + cost;
                    s_d.open.br   = s_d.open.br + BR_W'(in_branch);
                end
                if (brk_after) begin
                    s_d = close_way(s_d);
                end
            end
        end else if (out_ready) begin
            if (s_q.ovf || (s_q.idx == s_q.n - WC_W'(1))) begin
                s_d.emit = 1'b0;
                s_d.grp  = 1'b0;
                s_d.n    = '0;
                s_d.ovf  = 1'b0;
                s_d.idx  = '0;
            end else begin
                s_d.idx = s_q.idx + WC_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign in_ready    = !s_q.emit && !bnd;
    assign out_valid   = s_q.emit;
    assign out_tag     = s_q.tag;
    assign out_uncache = s_q.ovf;

    upc_out_sel #(.MAX_WAYS(MAX_WAYS), .WC_W(WC_W)) sel_i (
        .ways  (s_q.ways),
        .idx   (s_q.idx),
        .ovf   (s_q.ovf),
        .tag   (s_q.tag),
        .start (out_start),
        .uops  (out_uops),
        .br    (out_branches)
    );
endmodule

// File: rtl/uop_line_checks.sv
module uop_line_checks
    import uop_line_pkg::*;
#(
    parameter int MAX_BR = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [TAG_W-1:0]  out_tag,
    input logic [ADDR_W-1:0] out_start,
    input logic [UOP_W-1:0]  out_uops,
    input logic [BR_W-1:0]   out_branches,
    input logic              out_uncache
);
    p_region_tag_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_uncache |-> out_start[ADDR_W-1:REGION_LG] == out_tag);

    p_nonempty_way_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_uncache |-> out_uops != '0);

    p_branch_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_branches <= BR_W'(MAX_BR));

    p_uncache_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_uncache |-> out_uops == '0 && out_branches == '0);

    p_stall_input_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    p_hold_record_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_start) && $stable(out_uops)
            && $stable(out_branches) && $stable(out_uncache) && $stable(out_tag));
endmodule

bind uop_line_packer uop_line_checks #(.MAX_BR(MAX_BR)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_ready     (in_ready),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_tag      (out_tag),
    .out_start    (out_start),
    .out_uops     (out_uops),
    .out_branches (out_branches),
    .out_uncache  (out_uncache)
);

// File: tb/uop_line_packer_tb.sv
module uop_line_packer_tb_top;
    localparam int SLOTS = 6;
    localparam int MAXBR = 2;
    localparam int MAXW  = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_addr = '0;
    logic [3:0]  in_len = '0;
    logic [2:0]  in_uops = '0;
    logic        in_branch = 1'b0, in_uncond = 1'b0, in_rom = 1'b0, in_fused = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [10:0] out_tag;
    logic [15:0] out_start;
    logic [2:0]  out_uops;
    logic [1:0]  out_branches;
    logic        out_uncache;

    always #2.5 clk = ~clk;

    uop_line_packer dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_addr(in_addr), .in_len(in_len), .in_uops(in_uops), .in_branch(in_branch),
        .in_uncond(in_uncond), .in_rom(in_rom), .in_fused(in_fused),
        .out_valid(out_valid), .out_ready(out_ready), .out_tag(out_tag),
        .out_start(out_start), .out_uops(out_uops), .out_branches(out_branches),
        .out_uncache(out_uncache)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string phase = "R9 reset";

    // reference model state
    int o_act = 0, o_start = 0, o_uops = 0, o_br = 0;
    int g_act = 0, g_tag = 0, g_nxt = 0, g_ovf = 0;
    int gw_start[$], gw_uops[$], gw_br[$];
    int e_tag[$], e_start[$], e_uops[$], e_br[$], e_unc[$];
    string e_ph[$];

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic void m_close();
        if (o_act != 0) begin
            if (gw_start.size() < MAXW) begin
                gw_start.push_back(o_start);
                gw_uops.push_back(o_uops);
                gw_br.push_back(o_br);
            end else begin
                g_ovf = 1;
            end
            o_act = 0;
        end
    endfunction

    function automatic void m_flush();
        m_close();
        if (g_ovf != 0) begin
            e_tag.push_back(g_tag); e_start.push_back(g_tag << 5);
            e_uops.push_back(0); e_br.push_back(0); e_unc.push_back(1); e_ph.push_back(phase);
        end else begin
            foreach (gw_start[k]) begin
                e_tag.push_back(g_tag); e_start.push_back(gw_start[k]);
                e_uops.push_back(gw_uops[k]); e_br.push_back(gw_br[k]);
                e_unc.push_back(0); e_ph.push_back(phase);
            end
        end
        gw_start.delete(); gw_uops.delete(); gw_br.delete();
        g_act = 0; g_ovf = 0;
    endfunction

    function automatic void m_accept(int a, int l, int u, int b, int j, int r, int f);
        int cost;
        int disc;
        disc = (g_act == 0 || a != g_nxt) ? 1 : 0;
        if (g_act == 0) begin g_act = 1; g_tag = a >> 5; end
        g_nxt = (a + l) & 16'hFFFF;
        cost = (f != 0) ? 1 : u;
        if (r != 0 || disc != 0 || o_uops + cost > SLOTS || (b != 0 && o_br >= MAXBR)) m_close();
        if (o_act == 0) begin
            o_act = 1; o_start = a; o_uops = cost; o_br = b;
        end else begin
            o_uops += cost; o_br += b;
        end
        if (r != 0 || j != 0) m_close();
    endfunction

    task automatic send(input int a, input int l, input int u, input int b,
                        input int j, input int r, input int f);
        bit acc;
        if (g_act != 0 && (a >> 5) != g_tag) m_flush();
        acc = 0;
        while (!acc) begin
            @(negedge clk);
            in_valid = 1'b1; in_addr = 16'(a); in_len = 4'(l); in_uops = 3'(u);
            in_branch = b[0]; in_uncond = j[0]; in_rom = r[0]; in_fused = f[0];
            #1;
            acc = in_ready;
        end
        m_accept(a, l, u, b, j, r, f);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // record monitor
    initial begin
        bit held = 0;
        int h_start, h_uops, h_br, h_unc;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            out_ready = ($urandom_range(0, 9) < 7);
            #1;
            if (held) begin
                check("R8 hold valid", int'(out_valid), 1);
                check("R8 hold start", int'(out_start), h_start);
                check("R8 hold uops", int'(out_uops), h_uops);
                check("R8 hold branches", int'(out_branches), h_br);
                check("R8 hold uncache", int'(out_uncache), h_unc);
                held = 0;
            end
            if (out_valid) check("R8 input stalled", int'(in_ready), 0);
            if (out_valid && !out_ready) begin
                held = 1; h_start = out_start; h_uops = out_uops;
                h_br = out_branches; h_unc = out_uncache;
            end
            if (out_valid && out_ready) begin
                if (e_tag.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R8 unexpected record actual=%0h expected=none", out_start);
                end else begin
                    string ph;
                    ph = e_ph.pop_front();
                    check({ph, " / R1 tag"}, int'(out_tag), e_tag.pop_front());
                    check({ph, " / R8 start"}, int'(out_start), e_start.pop_front());
                    check({ph, " / R2 uops"}, int'(out_uops), e_uops.pop_front());
                    check({ph, " / R3 branches"}, int'(out_branches), e_br.pop_front());
                    check({ph, " / R7 uncache"}, int'(out_uncache), e_unc.pop_front());
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int a;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check("R9 reset out_valid", int'(out_valid), 0);
        check("R9 reset in_ready", int'(in_ready), 1);

        phase = "R2 slot limit and fused pair";
        for (int i = 0; i < 6; i++) send(16'h1000 + 2*i, 2, 1, 0, 0, 0, 0);
        send(16'h100C, 3, 2, 0, 0, 0, 0);
        send(16'h100F, 4, 2, 0, 0, 0, 1);

        phase = "R3 branch cap";
        for (int i = 0; i < 3; i++) send(16'h1040 + 2*i, 2, 1, 1, 0, 0, 0);

        phase = "R4 rom alone";
        send(16'h1080, 2, 1, 0, 0, 0, 0);
        send(16'h1082, 3, 4, 0, 0, 1, 0);
        send(16'h1085, 2, 1, 0, 0, 0, 0);

        phase = "R5 uncond end";
        send(16'h10C0, 2, 1, 1, 1, 0, 0);
        send(16'h10C2, 2, 1, 0, 0, 0, 0);

        phase = "R6 discontinuity";
        send(16'h1100, 2, 1, 0, 0, 0, 0);
        send(16'h1110, 2, 1, 0, 0, 0, 0);

        phase = "R1 region span";
        send(16'h115E, 6, 2, 0, 0, 0, 0);
        send(16'h1164, 2, 1, 0, 0, 0, 0);

        phase = "R7 overflow";
        for (int i = 0; i < 4; i++) send(16'h11A0 + 4*i, 4, 2, 0, 0, 1, 0);

        phase = "R7 three ways kept";
        for (int i = 0; i < 3; i++) send(16'h11E0 + 4*i, 4, 2, 0, 0, 1, 0);

        phase = "R8 random";
        a = 16'h2000;
        for (int i = 0; i < 600; i++) begin
            int l, u, b, j, r, f;
            if ($urandom_range(0, 19) == 0) a = $urandom_range(16'h2000, 16'hE000);
            l = $urandom_range(1, 15);
            r = ($urandom_range(0, 19) == 0) ? 1 : 0;
            f = (r == 0 && $urandom_range(0, 9) == 0) ? 1 : 0;
            u = (r != 0) ? $urandom_range(1, 7) : (f != 0 ? 2 : $urandom_range(1, 6));
            b = (f != 0 || $urandom_range(0, 4) == 0) ? 1 : 0;
            j = ($urandom_range(0, 19) == 0) ? 1 : 0;
            send(a, l, u, b, j, r, f);
            a = (a + l) & 16'hFFFF;
        end
        send(((g_tag + 4) << 5) & 16'hFFFF, 2, 1, 0, 0, 0, 0);
        for (int i = 0; i < 200 && e_tag.size() != 0; i++) @(negedge clk);
        repeat (4) @(negedge clk);
        check("R8 all records delivered", e_tag.size(), 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule